// File: doc/BRIEF.md
# Register Bit-Field Access Engine

This block lets a small controller core read or modify a bit field inside any 32-bit peripheral register without handling masks and shifts in its own datapath. The core names a register by its word address, gives the upper and lower bit indices of the field and, for a modification, an immediate of up to 8 bits. The engine then runs the bus cycles on a simple synchronous register bus.

A field read fetches the word and returns bits upper..lower, moved down to bit 0 and zero-filled to 16 bits. This result is meant for the core's first general register. A field modification reads the word, replaces only the named field and writes the word back. Each accepted request takes a fixed number of cycles, so the core's instruction timing does not depend on the field. A request whose indices are reversed, or whose field is wider than the operation allows, finishes at once with an error flag and makes no bus access.

Top module: `regfield_access`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, busy, done, err, bus_rd and bus_wr are 0 and rd_result is 0.
- R2: A field read of upper index H and lower index L returns register bits H..L on rd_result bits (H-L)..0. All higher result bits are 0.
- R3: A field read is accepted on the edge where req_valid is 1 and busy is 0. Counting that edge as the first, done is 1 after the fourth edge and rd_result holds the new value in that same cycle.
- R4: A field modification writes back the register with bits H..L replaced and every other bit unchanged from the value read.
- R5: The immediate fills the field from bit L upward. A field wider than the immediate receives zeros in its upper bits. A field narrower than the immediate receives only the immediate's low H-L+1 bits.
- R6: A field modification raises done after the eighth edge, counting the acceptance edge as the first. The bus write lands on that same edge.
- R7: A request with H less than L is rejected. done and err are both 1 after the acceptance edge, no bus read or write occurs, and rd_result keeps its value.
- R8: A read field wider than 16 bits, or a modification field wider than 8 bits, is rejected in the same way as R7. A 16-bit read field and an 8-bit modification field are accepted.
- R9: done is high for exactly one cycle per request. err is 1 only while done is 1.
- R10: While busy is 1, req_valid is ignored and the ignored request leaves no trace. A request presented in the cycle done is high is accepted.
- R11: An accepted request makes exactly one bus_rd pulse, in the cycle after acceptance. A modification also makes exactly one bus_wr pulse, in its last busy cycle. bus_rd and bus_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 = field modification, 0 = field read |
| req_addr | input | ADDR_W | Register address in 32-bit word units |
| req_hi | input | 5 | Upper bit index of the field |
| req_lo | input | 5 | Lower bit index of the field |
| req_imm | input | 8 | Immediate for a field modification |
| busy | output | 1 | An accepted request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected, valid with done |
| rd_result | output | 16 | Zero-extended field from the last successful read |
| bus_addr | output | ADDR_W | Register bus word address |
| bus_rd | output | 1 | Register bus read strobe; data is returned the next cycle |
| bus_wr | output | 1 | Register bus write strobe |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data, registered by the bus |

## Verification
Two events can fall in the same cycle: a new request and the completion of the one in flight. A request can also arrive in the middle of an operation. The bench raises a second request two cycles into a modification, with a different target. It then checks that this target is unchanged and that no extra completion appears. It also presents a read in the exact cycle done is high and checks that the read is accepted and returns its field with the normal four-cycle latency.

// File: rtl/regfield_pkg.sv
// Package: shared widths, the sequencer state type and a field span helper.
// Assumes 32-bit registers, so bit indices fit in five bits.
package regfield_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned IDX_W  = $clog2(REG_W);
    localparam int unsigned RES_W  = 16;
    localparam int unsigned IMM_W  = 8;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Number of bits between two indices, inclusive; only meaningful if hi >= lo.
    function automatic logic [IDX_W:0] field_span(input logic [IDX_W-1:0] hi,
                                                  input logic [IDX_W-1:0] lo);
        return {1'b0, hi} - {1'b0, lo} + {{IDX_W{1'b0}}, 1'b1};
    endfunction
endpackage

// File: rtl/regfield_check.sv
// Request validator: flags reversed indices and fields wider than the
// operation's limit (read result width, or immediate width for a write).
// Purely combinational; evaluated on the request inputs at acceptance.
module regfield_check #(
    parameter int unsigned IDX_W = regfield_pkg::IDX_W,
    parameter int unsigned RES_W = regfield_pkg::RES_W,
    parameter int unsigned IMM_W = regfield_pkg::IMM_W
) (
    input  logic             is_write,
    input  logic [IDX_W-1:0] hi,
    input  logic [IDX_W-1:0] lo,
    output logic             bad
);
    localparam logic [IDX_W:0] RD_LIMIT = (IDX_W+1)'(RES_W);
    localparam logic [IDX_W:0] WR_LIMIT = (IDX_W+1)'(IMM_W);

    logic [IDX_W:0] span;
    logic [IDX_W:0] limit;

    // Compute the field span and the limit that applies to this operation.
    always_comb begin
        span  = regfield_pkg::field_span(hi, lo);
        limit = is_write ? WR_LIMIT : RD_LIMIT;
        bad   = (hi < lo) || (span > limit);
    end
endmodule

// File: rtl/regfield_seq.sv
// Step sequencer: counts the fixed latency of each accepted request and
// issues the bus strobes and datapath enables at fixed steps.
// Assumes RD_LAT >= 4 and WR_LAT >= 5 so the read, capture and merge steps fit.
module regfield_seq #(
    parameter int unsigned RD_LAT = 4,
    parameter int unsigned WR_LAT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic reject,
    input  logic is_write,
    output logic busy,
    output logic done,
    output logic err,
    output logic rd_stb,
    output logic wr_stb,
    output logic cap_en,
    output logic merge_en,
    output logic load_res
);
    import regfield_pkg::*;

    localparam int unsigned STEP_W = $clog2(WR_LAT + 1);
    localparam logic [STEP_W-1:0] RD_LAST  = STEP_W'(RD_LAT - 1);
    localparam logic [STEP_W-1:0] WR_LAST  = STEP_W'(WR_LAT - 1);
    localparam logic [STEP_W-1:0] STEP_RD  = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_CAP = STEP_W'(2);
    localparam logic [STEP_W-1:0] STEP_MRG = STEP_W'(3);

    seq_state_e        state;
    logic [STEP_W-1:0] step;
    logic              op_wr;
    logic [STEP_W-1:0] last;

    // Pick the final step for the operation in flight.
    always_comb last = op_wr ? WR_LAST : RD_LAST;

    // Advance the step count, and raise done and err for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            step  <= '0;
            op_wr <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (state == SEQ_IDLE) begin
                if (start) begin
                    state <= SEQ_RUN;
                    step  <= STEP_W'(1);
                    op_wr <= is_write;
                end else if (reject) begin
                    done <= 1'b1;
                    err  <= 1'b1;
                end
            end else begin
                if (step == last) begin
                    state <= SEQ_IDLE;
                    step  <= '0;
                    done  <= 1'b1;
                end else begin
                    step <= step + STEP_W'(1);
                end
            end
        end
    end

    // Decode the step into bus strobes and datapath enables.
    always_comb begin
        busy     = (state == SEQ_RUN);
        rd_stb   = busy && (step == STEP_RD);
        cap_en   = busy && (step == STEP_CAP);
        merge_en = busy && op_wr && (step == STEP_MRG);
        wr_stb   = busy && op_wr && (step == WR_LAST);
        load_res = busy && !op_wr && (step == RD_LAST);
    end
endmodule

// File: rtl/regfield_datapath.sv
// Field datapath: holds the request's indices and immediate, builds the field
// mask, extracts a zero-extended field and inserts the immediate into a word.
// Assumes the bus returns read data in the cycle where cap_en is high.
module regfield_datapath #(
    parameter int unsigned REG_W = regfield_pkg::REG_W,
    parameter int unsigned IDX_W = regfield_pkg::IDX_W,
    parameter int unsigned RES_W = regfield_pkg::RES_W,
    parameter int unsigned IMM_W = regfield_pkg::IMM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] hi,
    input  logic [IDX_W-1:0] lo,
    input  logic [IMM_W-1:0] imm,
    input  logic [REG_W-1:0] rdata,
    input  logic             cap_en,
    input  logic             merge_en,
    input  logic             load_res,
    output logic [RES_W-1:0] result,
    output logic [REG_W-1:0] wdata
);
    logic [IDX_W-1:0] hi_q;
    logic [IDX_W-1:0] lo_q;
    logic [IMM_W-1:0] imm_q;
    logic [REG_W-1:0] word_q;
    logic [REG_W-1:0] fmask;
    logic [REG_W-1:0] extracted;
    logic [REG_W-1:0] imm_placed;
    logic [REG_W-1:0] merged;

    // One mask bit per register bit: set when the bit lies inside lo..hi.
    for (genvar b = 0; b < REG_W; b++) begin : g_mask
        localparam logic [IDX_W-1:0] BIT_IDX = IDX_W'(b);
        assign fmask[b] = (BIT_IDX >= lo_q) && (BIT_IDX <= hi_q);
    end

    // Shift the field down for reads and place the immediate for writes.
    always_comb begin
        extracted  = (word_q & fmask) >> lo_q;
        imm_placed = {{(REG_W-IMM_W){1'b0}}, imm_q} << lo_q;
        merged     = (word_q & ~fmask) | (imm_placed & fmask);
    end

    // Hold the request fields from acceptance until the operation ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            imm_q <= '0;
        end else if (take) begin
            hi_q  <= hi;
            lo_q  <= lo;
            imm_q <= imm;
        end
    end

    // Capture the fetched word and later replace it with the merged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (cap_en) begin
            word_q <= rdata;
        end else if (merge_en) begin
            word_q <= merged;
        end
    end

    // Publish the read result only when a read completes without error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (load_res) begin
            result <= extracted[RES_W-1:0];
        end
    end

    assign wdata = word_q;
endmodule

// File: rtl/regfield_access.sv
// Top: accepts field read or modification requests, validates them, and
// drives the register bus through the sequencer and datapath.
// Assumes a bus that returns read data one cycle after bus_rd.
module regfield_access #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned REG_W  = regfield_pkg::REG_W,
    parameter int unsigned IDX_W  = regfield_pkg::IDX_W,
    parameter int unsigned RES_W  = regfield_pkg::RES_W,
    parameter int unsigned IMM_W  = regfield_pkg::IMM_W,
    parameter int unsigned RD_LAT = 4,
    parameter int unsigned WR_LAT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_hi,
    input  logic [IDX_W-1:0]  req_lo,
    input  logic [IMM_W-1:0]  req_imm,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [RES_W-1:0]  rd_result,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  bus_rdata
);
    logic accept;
    logic bad;
    logic start;
    logic reject;
    logic cap_en;
    logic merge_en;
    logic load_res;

    // Split an accepted request into a good start or a rejection.
    always_comb begin
        accept = req_valid && !busy;
        start  = accept && !bad;
        reject = accept && bad;
    end

    regfield_check #(
        .IDX_W (IDX_W),
        .RES_W (RES_W),
        .IMM_W (IMM_W)
    ) u_check (
        .is_write (req_write),
        .hi       (req_hi),
        .lo       (req_lo),
        .bad      (bad)
    );

    regfield_seq #(
        .RD_LAT (RD_LAT),
        .WR_LAT (WR_LAT)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .reject   (reject),
        .is_write (req_write),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .rd_stb   (bus_rd),
        .wr_stb   (bus_wr),
        .cap_en   (cap_en),
        .merge_en (merge_en),
        .load_res (load_res)
    );

    regfield_datapath #(
        .REG_W (REG_W),
        .IDX_W (IDX_W),
        .RES_W (RES_W),
        .IMM_W (IMM_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (start),
        .hi       (req_hi),
        .lo       (req_lo),
        .imm      (req_imm),
        .rdata    (bus_rdata),
        .cap_en   (cap_en),
        .merge_en (merge_en),
        .load_res (load_res),
        .result   (rd_result),
        .wdata    (bus_wdata)
    );

    // Hold the target word address for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr <= '0;
        end else if (start) begin
            bus_addr <= req_addr;
        end
    end
endmodule

// File: rtl/regfield_access_sva.sv
// Protocol checker for regfield_access, attached with bind below.
// Observes ports only; recomputes field validity from the request inputs.
module regfield_access_sva #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned IDX_W  = regfield_pkg::IDX_W,
    parameter int unsigned RES_W  = regfield_pkg::RES_W,
    parameter int unsigned IMM_W  = regfield_pkg::IMM_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [IDX_W-1:0]  req_hi,
    input logic [IDX_W-1:0]  req_lo,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr
);
    logic [IDX_W:0] span;
    logic           oversize;
    logic           taken;

    // Independent view of whether the presented request is acceptable.
    always_comb begin
        span     = {1'b0, req_hi} - {1'b0, req_lo} + 1'b1;
        oversize = req_write ? (span > (IDX_W+1)'(IMM_W)) : (span > (IDX_W+1)'(RES_W));
        taken    = req_valid && !busy;
    end

    assert_bad_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && (req_hi < req_lo)) |=> (done && err && !busy && !bus_rd));

    assert_too_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && (req_hi >= req_lo) && oversize) |=> (done && err && !busy && !bus_rd));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_start_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && (req_hi >= req_lo) && !oversize) |=> (busy && bus_rd));

    assert_no_both_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_write_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (done && !err));

    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && !$past(bus_wr)) |-> $past(bus_rd, 3));

    assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr));
endmodule

bind regfield_access regfield_access_sva #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .RES_W  (RES_W),
    .IMM_W  (IMM_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_hi    (req_hi),
    .req_lo    (req_lo),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr)
);

// File: tb/regfield_access_test.sv
`timescale 1ns/1ps
module regfield_access_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [4:0]  req_hi = '0;
    logic [4:0]  req_lo = '0;
    logic [7:0]  req_imm = '0;
    logic        busy, done, err, bus_rd, bus_wr;
    logic [15:0] rd_result;
    logic [9:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    logic [31:0] mem [0:1023];
    int n_run = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int lat;
    logic e;

    always #10 clk = ~clk;

    regfield_access uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_hi (req_hi), .req_lo (req_lo), .req_imm (req_imm),
        .busy (busy), .done (done), .err (err), .rd_result (rd_result),
        .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
    );

    // Register bus model: registered read data, write on the strobe edge.
    always @(posedge clk) begin
        if (bus_rd) begin
            bus_rdata <= mem[bus_addr];
            rd_cnt    <= rd_cnt + 1;
        end
        if (bus_wr) begin
            mem[bus_addr] <= bus_wdata;
            wr_cnt        <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request, wait for done; returns latency in cycles and err.
    task automatic run_op(input logic wr, input logic [9:0] a, input logic [4:0] h,
                          input logic [4:0] l, input logic [7:0] d,
                          output int lt, output logic er);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        req_write = wr; req_addr = a; req_hi = h; req_lo = l; req_imm = d;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lt = 1;
        while (!done && lt < 40) begin
            @(posedge clk); @(negedge clk); lt++;
        end
        er = err;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 done", {31'b0, done}, 0);
        chk("R1 err", {31'b0, err}, 0);
        chk("R1 strobes", {30'b0, bus_rd, bus_wr}, 0);
        chk("R1 result", {16'b0, rd_result}, 0);
    endtask

    task automatic t_reads();
        mem[5] = 32'h1234_5678;
        run_op(1'b0, 10'd5, 5'd7, 5'd4, 8'h00, lat, e);
        chk("R3 read latency", lat, 4);
        chk("R2 read 7:4", {16'b0, rd_result}, 32'h7);
        chk("R11 read bus_rd count", rd_cnt, 1);
        chk("R11 read bus_wr count", wr_cnt, 0);
        @(negedge clk);
        chk("R9 done one cycle", {31'b0, done}, 0);
        run_op(1'b0, 10'd5, 5'd31, 5'd16, 8'h00, lat, e);
        chk("R8 16-bit read accepted", {31'b0, e}, 0);
        chk("R2 read 31:16", {16'b0, rd_result}, 32'h1234);
        run_op(1'b0, 10'd5, 5'd18, 5'd18, 8'h00, lat, e);
        chk("R2 read bit 18", {16'b0, rd_result}, 32'h1);
    endtask

    task automatic t_writes();
        mem[9] = 32'hFFFF_FFFF;
        run_op(1'b1, 10'd9, 5'd11, 5'd4, 8'h00, lat, e);
        chk("R6 write latency", lat, 8);
        chk("R4 write 11:4 keeps others", mem[9], 32'hFFFF_F00F);
        chk("R11 write bus_rd count", rd_cnt, 1);
        chk("R11 write bus_wr count", wr_cnt, 1);
        mem[10] = 32'h0;
        run_op(1'b1, 10'd10, 5'd2, 5'd1, 8'hFF, lat, e);
        chk("R5 truncated imm", mem[10], 32'h0000_0006);
        mem[11] = 32'hFFFF_FFFF;
        run_op(1'b1, 10'd11, 5'd31, 5'd26, 8'h05, lat, e);
        chk("R5 zero-extended imm", mem[11], 32'h17FF_FFFF);
        mem[14] = 32'h0;
        run_op(1'b1, 10'd14, 5'd31, 5'd24, 8'hA5, lat, e);
        chk("R8 8-bit write accepted", {31'b0, e}, 0);
        chk("R4 write top byte", mem[14], 32'hA500_0000);
    endtask

    task automatic t_errors();
        logic [15:0] prev;
        prev = rd_result;
        mem[20] = 32'hCAFE_F00D;
        run_op(1'b0, 10'd20, 5'd3, 5'd4, 8'h00, lat, e);
        chk("R7 reversed latency", lat, 1);
        chk("R7 reversed err", {31'b0, e}, 1);
        chk("R7 no bus access", rd_cnt + wr_cnt, 0);
        chk("R7 result kept", {16'b0, rd_result}, {16'b0, prev});
        @(negedge clk);
        chk("R9 err cleared", {30'b0, done, err}, 0);
        run_op(1'b0, 10'd20, 5'd16, 5'd0, 8'h00, lat, e);
        chk("R8 17-bit read rejected", {31'b0, e}, 1);
        chk("R8 read no bus access", rd_cnt + wr_cnt, 0);
        run_op(1'b1, 10'd20, 5'd8, 5'd0, 8'hFF, lat, e);
        chk("R8 9-bit write rejected", {31'b0, e}, 1);
        chk("R8 write left word", mem[20], 32'hCAFE_F00D);
    endtask

    // Second request during busy, then a read presented in the done cycle.
    task automatic t_overlap();
        int n;
        int dones;
        mem[12] = 32'h0;
        mem[13] = 32'hAAAA_AAAA;
        @(negedge clk);
        req_write = 1'b1; req_addr = 10'd12; req_hi = 5'd7; req_lo = 5'd0; req_imm = 8'h3C;
        req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        req_addr = 10'd13; req_imm = 8'h55; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(posedge clk); @(negedge clk); n++;
        end
        chk("R10 first write done", mem[12], 32'h0000_003C);
        req_write = 1'b0; req_addr = 10'd13; req_hi = 5'd7; req_lo = 5'd0;
        req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        dones = 0;
        while (!done && n < 40) begin
            @(posedge clk); @(negedge clk); n++;
        end
        chk("R10 done-cycle request latency", n, 4);
        chk("R10 done-cycle read value", {16'b0, rd_result}, 32'hAA);
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); @(negedge clk);
            if (done) dones++;
        end
        chk("R10 ignored request no done", dones, 0);
        chk("R10 ignored request no write", mem[13], 32'hAAAA_AAAA);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reads();
        t_writes();
        t_errors();
        t_overlap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule